// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block drives a 12-bit successive-approximation converter that talks over three wires: an active-low chip select, a serial clock generated here, and a serial data line returned by the converter. A start request pulls chip select low, which begins a conversion. The serial clock is held low while the converter works. The controller then decides that the conversion has finished, either by watching for the data line to rise or by waiting a fixed number of system cycles. After that it produces thirteen clock pulses and captures the data line on each rising clock edge.

The first captured bit is the converter's high framing bit and is thrown away. The next twelve bits arrive most significant first and form the result. Chip select is released on the thirteenth falling clock edge, and the word is presented with a one-cycle valid strobe. Chip select then stays high for a minimum hold time before another start request is taken. If the data line is being watched and never rises within the wait limit, the frame is abandoned and a one-cycle timeout flag is raised.

The serial clock half period is a whole number of system cycles, set by a parameter. With the default values and a 250 MHz system clock, the serial clock runs at about 2.08 MHz, below the converter's 2.1 MHz ceiling.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, chip select is high, the serial clock is low, the result is zero, and the valid and timeout outputs are low.
- R2: A start request seen while idle drives chip select low on the next clock edge. The serial clock stays low from then until the end of conversion has been decided.
- R3: With eoc_mode_i = 1, sampled at start, the first serial clock rise comes DIV_HALF + 3 cycles after the data line goes high (two synchronizer stages and one edge-detect cycle). If the line has not risen CONV_CYC cycles after chip select fell, chip select is raised, timeout_o pulses for one cycle, no valid strobe is issued, no clock pulse is produced, and the result keeps its old value.
- R4: With eoc_mode_i = 0, sampled at start, the first serial clock rise comes exactly CONV_CYC + DIV_HALF cycles after chip select falls, whatever the data line does. timeout_o is never raised in this mode.
- R5: Each frame has exactly 13 serial clock rising edges. Every high and low level of the serial clock lasts DIV_HALF system cycles, so the first and the thirteenth rises are 24 × DIV_HALF cycles apart.
- R6: The data line is sampled on each serial clock rise. The first sample (the framing bit) is discarded. The next 12 samples form result_o with the first of them in bit 11 and the last in bit 0.
- R7: Chip select rises on the same system clock edge as the 13th falling serial clock edge. valid_o is high for exactly that one following cycle, and result_o changes only together with valid_o.
- R8: Between the end of one frame and the next chip select fall, chip select stays high for at least CSH_CYC cycles. With start held high, the gap is CSH_CYC + 1 cycles.
- R9: A start request that arrives during a conversion, a shift or the chip-select hold is ignored. It does not produce an extra chip select fall, either then or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion; taken only while idle |
| eoc_mode_i | input | 1 | 1: data-line end of conversion with timeout; 0: fixed wait; sampled at start |
| adc_sdo_i | input | 1 | Serial data from the converter (asynchronous) |
| adc_cs_n_o | output | 1 | Active-low chip select to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter, idle low |
| result_o | output | 12 | Last captured conversion word |
| valid_o | output | 1 | One-cycle strobe when result_o updates |
| timeout_o | output | 1 | One-cycle flag when data-line end of conversion never arrived |

## Verification
The assertions take several things for granted about the inputs. The converter changes its data line only while the clock is idle or just after a falling serial clock edge, and it then holds the line for at least a full half period. The start and mode inputs are synchronous to the system clock. The stimulus follows these rules through a converter model that raises the framing bit after a chosen delay, moves to the next bit on each falling serial clock edge, returns zeros after the last bit, and drives low whenever chip select is high. In data-line mode the chosen delays stay below the wait limit. In fixed-wait mode the framing bit is raised before the wait ends. The timeout case comes from a model that never raises the line.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial ADC readout controller.
package adc_rd_pkg;
    // Frame sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/adc_sdo_sync.sv
`timescale 1ns/1ps
// Brings the converter's asynchronous data line into the clock domain with two
// flops and flags a low-to-high transition of the synchronized level.
// Assumes: the line is stable for many system cycles around each change.
module adc_sdo_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sdo_i,
    output logic level_o,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchronizer plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= sdo_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Level and rising transition of the synchronized line
    always_comb begin
        level_o = sync_q;
        rise_o  = sync_q & ~prev_q;
    end
endmodule

// File: rtl/sclk_gen.sv
`timescale 1ns/1ps
// Serial clock generator: while enabled, toggles the clock every HALF system
// cycles, starting from a full low phase. Gives one-cycle ticks that coincide
// with the edge on which the clock goes high or low.
// Assumes: HALF >= 2; when disabled, the clock is forced low and the phase
// counter restarts.
module sclk_gen #(
    parameter int HALF = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          wrap;

    // Phase counter and clock level register
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Edge ticks: asserted in the cycle before the clock level flips
    always_comb begin
        wrap   = en_i && (cnt_q == LAST);
        rise_o = wrap & ~sclk_q;
        fall_o = wrap &  sclk_q;
        sclk_o = sclk_q;
    end
endmodule

// File: rtl/cycle_timer.sv
`timescale 1ns/1ps
// Up-counter that restarts on clear and stops at a run-time limit; done is
// high while the count equals the limit.
// Assumes: the limit is held constant between clears.
module cycle_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] lim_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    // Count up from zero after a clear, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Limit comparison
    always_comb done_o = (cnt_q == lim_i);
endmodule

// File: rtl/frame_shifter.sv
`timescale 1ns/1ps
// Captures one serial frame: shifts the data line in on every rise tick and
// counts fall ticks. The leading framing bit is shifted out of the register by
// the later bits, so only the DATA_W most recent samples remain.
// Assumes: one rise tick precedes each fall tick.
module frame_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              sdo_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic [DATA_W-1:0] word_o,
    output logic              last_o
);
    localparam int FRAME = DATA_W + 1;
    localparam int CW    = $clog2(FRAME + 1);
    localparam logic [CW-1:0] LAST_FALL = CW'(FRAME - 1);

    logic [DATA_W-1:0] shreg_q;
    logic [CW-1:0]     falls_q;

    // Sample register, most significant first
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            shreg_q <= '0;
        end else if (rise_i) begin
            shreg_q <= {shreg_q[DATA_W-2:0], sdo_i};
        end
    end

    // Falling-edge counter for the frame length
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            falls_q <= '0;
        end else if (fall_i) begin
            falls_q <= falls_q + 1'b1;
        end
    end

    // Frame completes on the last falling edge
    always_comb begin
        last_o = fall_i && (falls_q == LAST_FALL);
        word_o = shreg_q;
    end
endmodule

// File: rtl/adc_readout_ctrl.sv
`timescale 1ns/1ps
// Serial ADC readout controller. Starts a conversion by lowering chip select,
// decides end of conversion from a data-line rise or a fixed wait, clocks out
// a framing bit plus DATA_W data bits, then holds chip select high for a
// minimum time.
// Assumes: DIV_HALF is chosen so that the serial clock meets the converter's
// maximum rate; CONV_CYC covers the converter's longest conversion.
module adc_readout_ctrl #(
    parameter int DATA_W   = 12,
    parameter int DIV_HALF = 60,
    parameter int CONV_CYC = 2250,
    parameter int CSH_CYC  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              eoc_mode_i,
    input  logic              adc_sdo_i,
    output logic              adc_cs_n_o,
    output logic              adc_sclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              timeout_o
);
    import adc_rd_pkg::*;

    localparam int TMR_MAX = (CONV_CYC > CSH_CYC) ? CONV_CYC : CSH_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] CONV_LIM = TMR_W'(CONV_CYC - 1);
    localparam logic [TMR_W-1:0] HOLD_LIM = TMR_W'(CSH_CYC - 1);

    rd_state_e         state_q;
    logic              mode_q;
    logic              cs_n_q;
    logic              valid_q;
    logic              tmo_q;
    logic [DATA_W-1:0] result_q;

    logic              sdo_lvl;
    logic              sdo_rise;
    logic              sck_rise;
    logic              sck_fall;
    logic              tmr_done;
    logic              tmr_clr;
    logic [TMR_W-1:0]  tmr_lim;
    logic              accept;
    logic              enter_hold;
    logic              frame_last;
    logic [DATA_W-1:0] frame_word;

    adc_sdo_sync sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdo_i   (adc_sdo_i),
        .level_o (sdo_lvl),
        .rise_o  (sdo_rise)
    );

    sclk_gen #(.HALF(DIV_HALF)) sclk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state_q == ST_SHIFT),
        .sclk_o (adc_sclk_o),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    cycle_timer #(.W(TMR_W)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .lim_i  (tmr_lim),
        .done_o (tmr_done)
    );

    frame_shifter #(.DATA_W(DATA_W)) shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .sdo_i  (sdo_lvl),
        .rise_i (sck_rise),
        .fall_i (sck_fall),
        .word_o (frame_word),
        .last_o (frame_last)
    );

    // Start acceptance, hold entry and timer control
    always_comb begin
        accept     = (state_q == ST_IDLE) && start_i;
        enter_hold = ((state_q == ST_CONV) && mode_q && !sdo_rise && tmr_done) ||
                     ((state_q == ST_SHIFT) && frame_last);
        tmr_clr    = accept || enter_hold;
        tmr_lim    = (state_q == ST_CONV) ? CONV_LIM : HOLD_LIM;
    end

    // Frame sequencer with chip select, strobes and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            valid_q  <= 1'b0;
            tmo_q    <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= 1'b0;
            tmo_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_CONV;
                        mode_q  <= eoc_mode_i;
                        cs_n_q  <= 1'b0;
                    end
                end
                ST_CONV: begin
                    if (mode_q && sdo_rise) begin
                        state_q <= ST_SHIFT;
                    end else if (tmr_done) begin
                        if (mode_q) begin
                            state_q <= ST_HOLD;
                            cs_n_q  <= 1'b1;
                            tmo_q   <= 1'b1;
                        end else begin
                            state_q <= ST_SHIFT;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (frame_last) begin
                        state_q  <= ST_HOLD;
                        cs_n_q   <= 1'b1;
                        valid_q  <= 1'b1;
                        result_q <= frame_word;
                    end
                end
                default: begin
                    if (tmr_done) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Output drive
    always_comb begin
        adc_cs_n_o = cs_n_q;
        valid_o    = valid_q;
        timeout_o  = tmo_q;
        result_o   = result_q;
    end
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for the readout controller, bound to every
// instance. Keeps its own counters of clock rises, level lengths and
// chip-select high time.
module adc_readout_ctrl_chk #(
    parameter int DATA_W   = 12,
    parameter int DIV_HALF = 60,
    parameter int CSH_CYC  = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_cs_n_o,
    input logic              adc_sclk_o,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              timeout_o
);
    localparam int FRAME = DATA_W + 1;
    localparam int LW    = $clog2(DIV_HALF + 1);
    localparam int HW    = $clog2(CSH_CYC + 1);

    logic          cs_prev_q;
    logic          sck_prev_q;
    logic [4:0]    rises_q;
    logic [LW-1:0] lvl_q;
    logic [HW-1:0] high_q;

    // Observation counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
            rises_q    <= '0;
            lvl_q      <= LW'(DIV_HALF);
            high_q     <= HW'(CSH_CYC);
        end else begin
            cs_prev_q  <= adc_cs_n_o;
            sck_prev_q <= adc_sclk_o;
            if (cs_prev_q && !adc_cs_n_o) begin
                rises_q <= '0;
            end else if (adc_sclk_o && !sck_prev_q && rises_q != 5'd31) begin
                rises_q <= rises_q + 1'b1;
            end
            if (adc_sclk_o != sck_prev_q) begin
                lvl_q <= '0;
            end else if (lvl_q != LW'(DIV_HALF)) begin
                lvl_q <= lvl_q + 1'b1;
            end
            if (!adc_cs_n_o) begin
                high_q <= '0;
            end else if (high_q != HW'(CSH_CYC)) begin
                high_q <= high_q + 1'b1;
            end
        end
    end

    AST_SCLK_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n_o |-> !adc_sclk_o); // R2
    AST_RISE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= 5'(FRAME)); // R5
    AST_LEVEL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk_o != sck_prev_q) |-> (lvl_q >= LW'(DIV_HALF - 1))); // R5
    AST_VALID_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (rises_q == 5'(FRAME) && adc_cs_n_o)); // R7
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o)); // R7
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_prev_q && !adc_cs_n_o) |-> (high_q >= HW'(CSH_CYC))); // R8
    AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!valid_o && adc_cs_n_o && rises_q == 5'd0)); // R3
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(
    .DATA_W   (DATA_W),
    .DIV_HALF (DIV_HALF),
    .CSH_CYC  (CSH_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_cs_n_o (adc_cs_n_o),
    .adc_sclk_o (adc_sclk_o),
    .result_o   (result_o),
    .valid_o    (valid_o),
    .timeout_o  (timeout_o)
);

// File: tb/adc_readout_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_readout_ctrl_tb_top;
    localparam int DIV_HALF = 60;
    localparam int CONV_CYC = 2250;
    localparam int CSH_CYC  = 100;

    typedef struct packed {
        logic [11:0] word;
        logic        mode;
        logic [15:0] delay;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{12'h000, 1'b1, 16'd300},
        '{12'hFFF, 1'b1, 16'd1500},
        '{12'h800, 1'b0, 16'd200},
        '{12'h001, 1'b0, 16'd2000},
        '{12'hA5C, 1'b1, 16'd40},
        '{12'h3C7, 1'b0, 16'd10},
        '{12'h7FE, 1'b1, 16'd2240},
        '{12'h555, 1'b0, 16'd1000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        eoc_mode = 1'b0;
    logic        sdo;
    logic        cs_n;
    logic        sclk;
    logic [11:0] result;
    logic        valid;
    logic        timeout;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    adc_readout_ctrl #(
        .DATA_W(12), .DIV_HALF(DIV_HALF), .CONV_CYC(CONV_CYC), .CSH_CYC(CSH_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .eoc_mode_i(eoc_mode),
        .adc_sdo_i(sdo), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk),
        .result_o(result), .valid_o(valid), .timeout_o(timeout)
    );

    // Converter model: framing bit after a delay, bits on falling clock edges
    logic [11:0] m_word = '0;
    int          m_delay = 10;
    logic        m_no_eoc = 1'b0;
    logic        m_eoc = 1'b0;
    int          m_falls = 0;

    always @(negedge cs_n) begin
        m_eoc = 1'b0;
        repeat (m_delay) @(posedge clk);
        #1;
        if (!cs_n && !m_no_eoc) m_eoc = 1'b1;
    end

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) m_falls <= 0;
        else      m_falls <= m_falls + 1;
    end

    assign sdo = (cs_n || !m_eoc) ? 1'b0 :
                 (m_falls == 0)   ? 1'b1 :
                 (m_falls <= 12)  ? m_word[12 - m_falls] : 1'b0;

    // Port monitor: edge times and counts
    int   cyc = 0;
    logic prev_cs = 1'b1;
    logic prev_sck = 1'b0;
    int   cs_falls = 0;
    int   t_fall = 0;
    int   t_rise_cs = 0;
    int   gap = 0;
    int   rises = 0;
    int   t_first = 0;
    int   t_last = 0;
    int   to_seen = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                cs_falls = cs_falls + 1;
                t_fall = cyc;
                gap = cyc - t_rise_cs;
                rises = 0;
            end
            if (!prev_cs && cs_n) t_rise_cs = cyc;
            if (!prev_sck && sclk) begin
                if (rises == 0) t_first = cyc;
                t_last = cyc;
                rises = rises + 1;
            end
            if (timeout) to_seen = to_seen + 1;
        end
        prev_cs = cs_n;
        prev_sck = sclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic mode);
        @(negedge clk);
        eoc_mode = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        int n = 0;
        while (!valid && n < 8000) begin
            @(negedge clk);
            n++;
        end
        seen = valid;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
        finish_run();
    end

    initial begin
        bit seen;
        int n;
        int falls0;

        // R1: reset state
        repeat (6) @(negedge clk);
        check(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        check(sclk == 1'b0, "R1 sclk in reset", int'(sclk), 0);
        check(result == 12'h000, "R1 result in reset", int'(result), 0);
        check(valid == 1'b0 && timeout == 1'b0, "R1 strobes in reset",
              int'({valid, timeout}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0, "R1 idle after reset", int'({cs_n, sclk}), 2);

        // Table of frames in both end-of-conversion modes
        foreach (VECS[i]) begin
            m_word = VECS[i].word;
            m_delay = int'(VECS[i].delay);
            m_no_eoc = 1'b0;
            pulse_start(VECS[i].mode);
            check(cs_n == 1'b0 && sclk == 1'b0, "R2 cs low, sclk idle after start",
                  int'({cs_n, sclk}), 0);
            wait_valid(seen);
            check(seen, "R7 valid strobe", int'(seen), 1);
            check(result == VECS[i].word, "R6 captured word", int'(result), int'(VECS[i].word));
            check(cs_n == 1'b1, "R7 cs high with valid", int'(cs_n), 1);
            check(rises == 13, "R5 clock rises per frame", rises, 13);
            check(t_last - t_first == 24 * DIV_HALF, "R5 clock period",
                  t_last - t_first, 24 * DIV_HALF);
            if (VECS[i].mode)
                check(t_first - t_fall == m_delay + DIV_HALF + 3, "R3 start on data-line rise",
                      t_first - t_fall, m_delay + DIV_HALF + 3);
            else
                check(t_first - t_fall == CONV_CYC + DIV_HALF, "R4 start after fixed wait",
                      t_first - t_fall, CONV_CYC + DIV_HALF);
            @(negedge clk);
            check(valid == 1'b0, "R7 valid one cycle", int'(valid), 0);
            repeat (CSH_CYC + 5) @(negedge clk);
        end
        check(to_seen == 0, "R4 no timeout in table run", to_seen, 0);

        // R3: data line never rises in data-line mode
        m_no_eoc = 1'b1;
        m_delay = 5;
        pulse_start(1'b1);
        n = 0;
        while (!timeout && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(timeout == 1'b1, "R3 timeout raised", int'(timeout), 1);
        check(valid == 1'b0 && cs_n == 1'b1, "R3 no valid, cs released", int'({valid, cs_n}), 1);
        check(rises == 0, "R3 no clock on timeout", rises, 0);
        check(result == 12'h555, "R3 result kept", int'(result), 12'h555);
        @(negedge clk);
        check(timeout == 1'b0, "R3 timeout one cycle", int'(timeout), 0);
        repeat (CSH_CYC + 5) @(negedge clk);
        m_no_eoc = 1'b0;

        // R9: starts during conversion and during hold are ignored
        falls0 = cs_falls;
        m_word = 12'h9B3;
        m_delay = 800;
        pulse_start(1'b1);
        repeat (400) @(negedge clk);
        pulse_start(1'b0);
        wait_valid(seen);
        check(seen && result == 12'h9B3, "R9 frame unaffected by busy start",
              int'(result), 12'h9B3);
        repeat (3) @(negedge clk);
        pulse_start(1'b1);
        repeat (300) @(negedge clk);
        check(cs_falls - falls0 == 1, "R9 single chip select fall", cs_falls - falls0, 1);
        check(cs_n == 1'b1, "R9 still idle", int'(cs_n), 1);

        // R8: start held high, back-to-back frames keep the minimum gap
        m_word = 12'h2E1;
        m_delay = 100;
        @(negedge clk);
        eoc_mode = 1'b1;
        start = 1'b1;
        wait_valid(seen);
        falls0 = cs_falls;
        n = 0;
        while (cs_falls == falls0 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(gap >= CSH_CYC, "R8 minimum chip select high", gap, CSH_CYC);
        check(gap == CSH_CYC + 1, "R8 gap with start held", gap, CSH_CYC + 1);
        @(negedge clk);
        wait_valid(seen);
        check(seen && result == 12'h2E1, "R6 back-to-back word", int'(result), 12'h2E1);
        repeat (CSH_CYC + 5) @(negedge clk);

        finish_run();
    end
endmodule